// File: doc/BRIEF.md
# Configurable Open-Drain I/O Port Bank

This block holds a bank of 4-bit bidirectional I/O ports for a small accumulator-style processor. A port write command copies the 4-bit accumulator value into that port's output latch. A port read command returns the port's synchronized pin levels to the accumulator in the same cycle. By default a pin behaves quasi-bidirectionally. A latch bit of 0 pulls the pin low. A latch bit of 1 releases it, so an external pull-up or another driver sets the level that is read back.

The first ports in the bank share their pins with analog inputs. For these ports, a per-bit configuration register selects digital or analog use. The remaining port has a per-bit configuration register that selects open-drain or push-pull drive instead. Each pad gets a separate output-enable and output-level signal, so a released pin has its output enable low.

Top module: `od_port_bank`

## Requirements
- R1: After reset every output latch bit is 1 and every configuration bit is 0. All pad output enables are therefore low.
- R2: A write command (`cmd_valid_i`=1, `cmd_write_i`=1) to a port index below the port count loads `acc_i` into that port's latch. The new value appears at the pads one clock later. A write to an index of 3 or more changes nothing.
- R3: On an analog-shared port (index 0 or 1) in digital mode, latch bit 0 gives output enable 1 with level 0, and latch bit 1 gives output enable 0 (released).
- R4: On the drive-select port (index 2), configuration bit 0 gives the open-drain behaviour of R3. Configuration bit 1 gives output enable 1 with the level equal to the latch bit.
- R5: A configuration write (`cfg_we_i`=1) loads `cfg_data_i` into the selected port's configuration register bit by bit. It takes effect one clock later, and each bit controls only its own pin. A configuration write to an index of 3 or more changes nothing.
- R6: On an analog-shared port, configuration bit 1 selects analog mode. The pin's output enable is then 0 whatever the latch holds, and that bit reads back as 0.
- R7: A read command (`cmd_valid_i`=1, `cmd_write_i`=0) returns the pin levels seen through a two-flop synchronizer. These are the pin values sampled two clock edges earlier, with bit b of port p at pin index 4p+b.
- R8: A pin whose latch bit is 0 and which is actively driven reads back as 0. A released pin reads back as its externally resolved level.
- R9: `acc_o` is 0 in any cycle without a read command, and also for a read of an index of 3 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Port command present this cycle |
| cmd_write_i | input | 1 | 1 = latch write, 0 = pin read |
| cmd_port_i | input | 2 | Port index of the command |
| acc_i | input | 4 | Accumulator value for a latch write |
| acc_o | output | 4 | Read data returned to the accumulator |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_port_i | input | 2 | Port index of the configuration write |
| cfg_data_i | input | 4 | Mode bits (analog ports) or drive-select bits (drive port) |
| pad_in_i | input | 12 | Resolved pin levels, pin 4p+b |
| pad_oe_o | output | 12 | Pad output enable per pin |
| pad_do_o | output | 12 | Pad output level per pin |

## Verification
On every cycle, the assertions check three things. An enabled open-drain pad never drives high. An analog-mode pin neither drives nor reads as anything but 0. A latch write lands in the latch on the next edge, and the read bus is quiet when no read is issued.

Some behaviour only the bench's scenarios can show. These include the two-cycle synchronizer delay between a pin change and the value read, and the readback of externally pulled-low pins. They also include push-pull drive of a high level, per-bit independence of the configuration, and that out-of-range indices are ignored. The bench's reference model covers these with directed sequences and a long random run.

// File: rtl/od_port_bank_pkg.sv
package od_port_bank_pkg;
  typedef enum logic {
    KIND_ANALOG = 1'b0,
    KIND_DRIVE  = 1'b1
  } port_kind_e;

  function automatic port_kind_e kind_of(input int port, input int num_analog);
    return (port < num_analog) ? KIND_ANALOG : KIND_DRIVE;
  endfunction
endpackage

// File: rtl/od_sync2.sv
module od_sync2 #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // idle pins sit pulled high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/od_port_cell.sv
module od_port_cell
  import od_port_bank_pkg::*;
#(
  parameter int         W    = 4,
  parameter port_kind_e KIND = KIND_ANALOG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         cfg_we_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] cfg_i,
  input  logic [W-1:0] pin_sync_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] do_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] latch_q, cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1;
      cfg_q   <= '0;
    end else begin
      if (wr_i)     latch_q <= data_i;
      if (cfg_we_i) cfg_q   <= cfg_i;
    end
  end

  generate
    if (KIND == KIND_ANALOG) begin : g_analog
      // cfg bit = analog mode: driver off, digital read masked
      assign oe_o = ~cfg_q & ~latch_q;
      assign do_o = '0;
      assign rd_o = pin_sync_i & ~cfg_q;

      assert_analog_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((oe_o & cfg_q) == '0) && ((rd_o & cfg_q) == '0));
      assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((oe_o & latch_q) == '0) && (do_o == '0));
    end else begin : g_drive
      // cfg bit = push-pull; 0 keeps open-drain
      assign oe_o = cfg_q | ~latch_q;
      assign do_o = cfg_q & latch_q;
      assign rd_o = pin_sync_i;

      assert_od_never_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((oe_o & do_o & ~cfg_q) == '0));
    end
  endgenerate

  assert_latch_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (latch_q == $past(data_i)));
  assert_cfg_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_q == $past(cfg_i)));
endmodule

// File: rtl/od_port_bank.sv
module od_port_bank
  import od_port_bank_pkg::*;
#(
  parameter int NUM_PORTS  = 3,
  parameter int PORT_W     = 4,
  parameter int NUM_ANALOG = 2,
  parameter int SEL_W      = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  input  logic                          cmd_write_i,
  input  logic [SEL_W-1:0]              cmd_port_i,
  input  logic [PORT_W-1:0]             acc_i,
  output logic [PORT_W-1:0]             acc_o,
  input  logic                          cfg_we_i,
  input  logic [SEL_W-1:0]              cfg_port_i,
  input  logic [PORT_W-1:0]             cfg_data_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   pad_in_i,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_oe_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_do_o
);
  localparam int PINS = NUM_PORTS * PORT_W;

  logic [PINS-1:0]   pin_sync;
  logic [PORT_W-1:0] rd_data [NUM_PORTS];
  logic              rd_req;

  od_sync2 #(.W(PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_sel, cfg_sel;
    assign wr_sel  = cmd_valid_i && cmd_write_i && (cmd_port_i == SEL_W'(p));
    assign cfg_sel = cfg_we_i && (cfg_port_i == SEL_W'(p));

    od_port_cell #(
      .W   (PORT_W),
      .KIND(kind_of(p, NUM_ANALOG))
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_sel),
      .cfg_we_i  (cfg_sel),
      .data_i    (acc_i),
      .cfg_i     (cfg_data_i),
      .pin_sync_i(pin_sync[p*PORT_W +: PORT_W]),
      .oe_o      (pad_oe_o[p*PORT_W +: PORT_W]),
      .do_o      (pad_do_o[p*PORT_W +: PORT_W]),
      .rd_o      (rd_data[p])
    );
  end

  assign rd_req = cmd_valid_i && !cmd_write_i;

  always_comb begin
    acc_o = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rd_req && cmd_port_i == SEL_W'(p)) acc_o = rd_data[p];
  end

  assert_read_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |-> (acc_o == '0));
endmodule

// File: tb/od_port_bank_tb.sv
module od_port_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0, cfg_we = 0;
  logic [1:0]  cmd_port = 0, cfg_port = 0;
  logic [3:0]  acc_in = 0, cfg_data = 0;
  logic [3:0]  acc_out;
  logic [11:0] ext_low = 0;
  logic [11:0] pad_oe, pad_do;
  wire  [11:0] pin;

  int checks = 0, failures = 0;

  // pull-up model, external open-drain pull-downs
  assign pin = ((pad_oe & pad_do) | ~pad_oe) & ~ext_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  od_port_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_write_i(cmd_write), .cmd_port_i(cmd_port),
    .acc_i(acc_in), .acc_o(acc_out),
    .cfg_we_i(cfg_we), .cfg_port_i(cfg_port), .cfg_data_i(cfg_data),
    .pad_in_i(pin), .pad_oe_o(pad_oe), .pad_do_o(pad_do)
  );

  // reference state
  logic [3:0]  m_lat [3];
  logic [3:0]  m_cfg [3];
  logic [11:0] m_s1, m_s2;

  task automatic model_reset();
    for (int p = 0; p < 3; p++) begin m_lat[p] = 4'hF; m_cfg[p] = 4'h0; end
    m_s1 = '1; m_s2 = '1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [11:0] e_oe, e_do;
    logic [3:0]  e_acc;
    for (int p = 0; p < 3; p++)
      for (int b = 0; b < 4; b++) begin
        int i = p*4 + b;
        if (p < 2) begin
          e_oe[i] = !m_cfg[p][b] && !m_lat[p][b];
          e_do[i] = 1'b0;
        end else begin
          e_oe[i] = m_cfg[p][b] || !m_lat[p][b];
          e_do[i] = m_cfg[p][b] && m_lat[p][b];
        end
      end
    e_acc = 4'h0;
    if (cmd_valid && !cmd_write && cmd_port < 3) begin
      e_acc = m_s2[cmd_port*4 +: 4];
      if (cmd_port < 2) e_acc = e_acc & ~m_cfg[cmd_port];
    end
    chk("R3/R4/R6", "pad_oe analog ports", int'(pad_oe[7:0]), int'(e_oe[7:0]));
    chk("R4", "pad_oe drive port", int'(pad_oe[11:8]), int'(e_oe[11:8]));
    chk("R4", "pad_do", int'(pad_do), int'(e_do));
    chk("R7/R8/R9", "acc_o", int'(acc_out), int'(e_acc));
  endtask

  // drive at negedge, check, then advance model across posedge
  task automatic cyc(input logic v, input logic w, input logic [1:0] port, input logic [3:0] a,
                     input logic cw, input logic [1:0] cp, input logic [3:0] cd, input logic [11:0] xl);
    logic [11:0] pin_pre;
    @(negedge clk);
    cmd_valid = v; cmd_write = w; cmd_port = port; acc_in = a;
    cfg_we = cw; cfg_port = cp; cfg_data = cd; ext_low = xl;
    #1;
    compare();
    pin_pre = pin;
    @(posedge clk);
    m_s2 = m_s1; m_s1 = pin_pre;
    if (v && w && port < 3) m_lat[port] = a;
    if (cw && cp < 3) m_cfg[cp] = cd;
  endtask

  task automatic rd(input logic [1:0] p, input logic [11:0] xl);
    cyc(1, 0, p, 4'h0, 0, 2'd0, 4'h0, xl);
  endtask
  task automatic wr(input logic [1:0] p, input logic [3:0] a, input logic [11:0] xl);
    cyc(1, 1, p, a, 0, 2'd0, 4'h0, xl);
  endtask
  task automatic cf(input logic [1:0] p, input logic [3:0] d, input logic [11:0] xl);
    cyc(0, 0, 2'd0, 4'h0, 1, p, d, xl);
  endtask
  task automatic idle(input logic [11:0] xl);
    cyc(0, 0, 2'd0, 4'h0, 0, 2'd0, 4'h0, xl);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    #(CLK_PERIOD*2 + 1);
    // R1: reset state, all released
    chk("R1", "pad_oe in reset", int'(pad_oe), 0);
    chk("R1", "acc_o in reset", int'(acc_out), 0);
    @(negedge clk); rst_n = 1;
    idle(0); idle(0);
    // R1: released pins read high
    rd(0, 0); rd(2, 0);
    // R2/R3: write port0, pull-downs visible
    wr(0, 4'b0101, 0);
    idle(0); idle(0);
    rd(0, 0);
    // R8: external low on released pin of port1, sync delay R7
    idle(12'h020); rd(1, 12'h020); rd(1, 12'h020); rd(1, 12'h020); rd(1, 0); rd(1, 0); rd(1, 0);
    // R4: push-pull on port2 bits 1,3
    wr(2, 4'b0110, 0);
    cf(2, 4'b1010, 0);
    idle(0); idle(0); rd(2, 0);
    // R5: per-bit independence, R6: analog mode masks
    wr(0, 4'b0000, 0);
    cf(0, 4'b0011, 0);
    idle(0); idle(0); rd(0, 0);
    cf(1, 4'b1000, 12'h080); idle(12'h080); idle(12'h080); rd(1, 12'h080);
    // R2/R5/R9: out-of-range index ignored
    wr(3, 4'b0000, 0); cf(3, 4'b1111, 0); rd(3, 0); idle(0);
    rd(0, 0); rd(1, 0); rd(2, 0);
    // random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r = $urandom;
      cyc(r[0], r[1], r[3:2], r[7:4], r[8] & r[9], r[11:10], r[15:12],
          (r[16] ? 12'(r[31:20]) : 12'h0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule